// File: doc/BRIEF.md
# I2C Target Receive DMA Engine

This block is the receive half of an I2C target port running in packet mode. A target front end that has already decoded the bus conditions feeds it a stream of events: an address strobe that carries the received address byte, byte strobes that carry data, and a stop strobe. When the address byte selects this target for a write, the engine opens a packet. It copies each data byte into memory through a byte-wide request/acknowledge write port, starting at a programmed base address and limited by a programmed buffer length.

Once the stop has been seen and every memory write has been acknowledged, the engine raises a group of packet status bits. It drives a shared interrupt line that also carries a pending indication from the master side of the same port. Software programs the engine through a simple register write port. It reads progress from two status words: a received-length word and an interrupt status word.

Top module: `i2c_tgt_rx_dma`

## Requirements
- R1: A start is accepted when `addr_stb` is high, `addr_byte[7:1]` equals the target address and `addr_byte[0]` is 0 (write). An accepted start clears the received-length field to zero on the next cycle, before any byte of the new packet is stored.
- R2: Each accepted data byte is written at the current DMA address. The address then steps by one, the remaining length drops by one and the received length rises by one. The received length is shown in `len_sts[28:16]`.
- R3: Select 3 is the buffer length register. A write there loads the 11-bit length from `reg_wr_data[26:16]` only when `reg_wr_data[31]` is 1 in the same write; otherwise the length is left unchanged.
- R4: A byte that arrives when the remaining length is zero is dropped without a memory write and without counting. The packet still completes normally at stop.
- R5: After a stop, once all outstanding writes are acknowledged, status bits 16, 7, 4 and 2 (packet done, address matched, normal stop, receive done) are set together in `int_sts`.
- R6: A write to select 6 with `reg_wr_data[16]` = 1 clears `int_sts[16:0]`. A write to select 6 with bit 16 at 0 has no effect.
- R7: `irq` is high when `mst_irq_pend` is high, or when any `int_sts` bit is high while the same bit position is set in the interrupt enable register (select 5). The line stays high, or goes high again, while either side is still pending.
- R8: Bytes are accepted only when all three enables are set: target enable (select 0 bit 1), receive DMA enable (select 1 bit 9) and packet mode enable (select 1 bit 16). The target address is select 2 bits 6:0, and the base address is select 4.
- R9: `mem_addr` and `mem_data` hold steady while `mem_req` waits for `mem_ack`. One byte that arrives during an outstanding write is kept in a skid register and written next.
- R10: An address strobe for another address, or for the read direction, opens no packet. Its bytes and stop cause no write, no length change and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select (0 func, 1 cmd, 2 target addr, 3 buffer length, 4 base, 5 int enable, 6 int status) |
| reg_wr_data | input | 32 | Register write data |
| addr_stb | input | 1 | Address byte received |
| addr_byte | input | 8 | Address byte: 7-bit address over direction bit |
| byte_vld | input | 1 | Data byte received |
| byte_data | input | 8 | Data byte |
| stop_det | input | 1 | Stop condition detected |
| mst_irq_pend | input | 1 | Master-side pending and enabled interrupt |
| mem_req | output | 1 | Memory byte write request |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory write accepted |
| len_sts | output | 32 | Received length in bits 28:16 |
| int_sts | output | 32 | Packet interrupt status |
| irq | output | 1 | Shared interrupt line |

## Verification
The in-line properties watch the per-cycle rules on every cycle. These are the rules that a request stays stable until acknowledged, that the received count clears after a start and never rises by more than one, that no write starts with an exhausted buffer, that a completed packet sets its four status bits, that the acknowledge write clears the group, and that master pending keeps the line high. Only the bench scenarios can show the end-to-end results. These are the exact addresses and data that reach memory, the truncation at the programmed length, the qualifier on the length write, the rejection of foreign and read-direction addresses, and the gating by the three enables. They also include the re-assertion of the shared line after the master side lets go and the masking by the enable register.

// File: rtl/i2c_trx_pkg.sv
package i2c_trx_pkg;
  typedef enum logic [2:0] {
    SEL_FUNC   = 3'd0,
    SEL_CMD    = 3'd1,
    SEL_TADDR  = 3'd2,
    SEL_BUFLEN = 3'd3,
    SEL_BASE   = 3'd4,
    SEL_IEN    = 3'd5,
    SEL_ISTS   = 3'd6
  } reg_sel_e;

  localparam int BIT_TGT_EN   = 1;
  localparam int BIT_RXDMA_EN = 9;
  localparam int BIT_PKT_EN   = 16;
  localparam int BIT_LEN_W1   = 31;
  localparam int LEN_LSB      = 16;
  localparam int CNT_LSB      = 16;

  localparam int STS_PKT_DONE = 16;
  localparam int STS_MATCH    = 7;
  localparam int STS_STOP     = 4;
  localparam int STS_RX_DONE  = 2;
endpackage

// File: rtl/i2c_trx_cfg.sv
module i2c_trx_cfg
  import i2c_trx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic              rx_enabled,
  output logic [6:0]        tgt_addr,
  output logic [LEN_W-1:0]  buf_len,
  output logic [ADDR_W-1:0] base_addr,
  output logic [31:0]       int_en
);
  logic              tgt_en_q, tgt_en_d;
  logic              rxdma_q, rxdma_d;
  logic              pkt_q, pkt_d;
  logic [6:0]        taddr_q, taddr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [31:0]       ien_q, ien_d;

  always_comb begin
    tgt_en_d = tgt_en_q;
    rxdma_d  = rxdma_q;
    pkt_d    = pkt_q;
    taddr_d  = taddr_q;
    len_d    = len_q;
    base_d   = base_q;
    ien_d    = ien_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_FUNC:  tgt_en_d = wr_data[BIT_TGT_EN];
        SEL_CMD: begin
          rxdma_d = wr_data[BIT_RXDMA_EN];
          pkt_d   = wr_data[BIT_PKT_EN];
        end
        SEL_TADDR: taddr_d = wr_data[6:0];
        SEL_BUFLEN: if (wr_data[BIT_LEN_W1]) len_d = wr_data[LEN_LSB +: LEN_W];
        SEL_BASE:  base_d = wr_data[ADDR_W-1:0];
        SEL_IEN:   ien_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_en_q <= 1'b0;
      rxdma_q  <= 1'b0;
      pkt_q    <= 1'b0;
      taddr_q  <= '0;
      len_q    <= '0;
      base_q   <= '0;
      ien_q    <= '0;
    end else if (wr_en) begin
      tgt_en_q <= tgt_en_d;
      rxdma_q  <= rxdma_d;
      pkt_q    <= pkt_d;
      taddr_q  <= taddr_d;
      len_q    <= len_d;
      base_q   <= base_d;
      ien_q    <= ien_d;
    end
  end

  assign rx_enabled = tgt_en_q & rxdma_q & pkt_q;
  assign tgt_addr   = taddr_q;
  assign buf_len    = len_q;
  assign base_addr  = base_q;
  assign int_en     = ien_q;

  AST_LEN_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_BUFLEN && !wr_data[BIT_LEN_W1]) |=> $stable(len_q)); // R3
endmodule

// File: rtl/i2c_trx_dma.sv
module i2c_trx_dma #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enabled,
  input  logic [6:0]        tgt_addr,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              addr_stb,
  input  logic [7:0]        addr_byte,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              stop_det,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  input  logic              mem_ack,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic              pkt_done
);
  logic              active_q, active_d;
  logic              stp_q, stp_d;
  logic              req_v_q, req_v_d;
  logic [ADDR_W-1:0] req_a_q, req_a_d;
  logic [7:0]        req_b_q, req_b_d;
  logic              skd_v_q, skd_v_d;
  logic [ADDR_W-1:0] skd_a_q, skd_a_d;
  logic [7:0]        skd_b_q, skd_b_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic start, ack, req_busy, skd_busy, take;

  always_comb begin
    start    = addr_stb & rx_enabled & (addr_byte[7:1] == tgt_addr) & ~addr_byte[0];
    ack      = req_v_q & mem_ack;
    req_busy = (req_v_q & ~ack) | (ack & skd_v_q);
    skd_busy = skd_v_q & ~ack;
    take     = byte_vld & active_q & ~stp_q & ~start & (rem_q != '0)
             & ~(req_busy & skd_busy);
    pkt_done = stp_q & ~req_v_q & ~skd_v_q & ~start;

    req_v_d  = req_busy;
    req_a_d  = req_a_q;
    req_b_d  = req_b_q;
    skd_v_d  = skd_busy;
    skd_a_d  = skd_a_q;
    skd_b_d  = skd_b_q;
    cur_d    = cur_q;
    rem_d    = rem_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    stp_d    = stp_q;

    if (ack && skd_v_q) begin
      req_a_d = skd_a_q;
      req_b_d = skd_b_q;
    end
    if (take) begin
      if (!req_busy) begin
        req_v_d = 1'b1;
        req_a_d = cur_q;
        req_b_d = byte_data;
      end else begin
        skd_v_d = 1'b1;
        skd_a_d = cur_q;
        skd_b_d = byte_data;
      end
      cur_d = cur_q + 1'b1;
      rem_d = rem_q - 1'b1;
      cnt_d = cnt_q + 1'b1;
    end
    if (start) begin
      active_d = 1'b1;
      stp_d    = 1'b0;
      cur_d    = base_addr;
      rem_d    = buf_len;
      cnt_d    = '0;
    end else begin
      if (stop_det && active_q && !stp_q) stp_d = 1'b1;
      if (pkt_done) begin
        active_d = 1'b0;
        stp_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      stp_q    <= 1'b0;
      req_v_q  <= 1'b0;
      req_a_q  <= '0;
      req_b_q  <= '0;
      skd_v_q  <= 1'b0;
      skd_a_q  <= '0;
      skd_b_q  <= '0;
      cur_q    <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      stp_q    <= stp_d;
      req_v_q  <= req_v_d;
      skd_v_q  <= skd_v_d;
      if (req_v_d) begin
        req_a_q <= req_a_d;
        req_b_q <= req_b_d;
      end
      if (skd_v_d) begin
        skd_a_q <= skd_a_d;
        skd_b_q <= skd_b_d;
      end
      cur_q <= cur_d;
      rem_q <= rem_d;
      cnt_q <= cnt_d;
    end
  end

  assign mem_req  = req_v_q;
  assign mem_addr = req_a_q;
  assign mem_data = req_b_q;
  assign rx_cnt   = cnt_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R9
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rx_cnt == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != $past(rx_cnt)) |-> (rx_cnt == '0 || rx_cnt == CNT_W'($past(rx_cnt) + 1'b1))); // R2
  AST_NO_WR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0 && !start && !req_v_q && !skd_v_q) |=> !mem_req); // R4
  AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start && !req_v_q && !skd_v_q) |=> !mem_req); // R10
endmodule

// File: rtl/i2c_trx_irq.sv
module i2c_trx_irq
  import i2c_trx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ack_wr,
  input  logic        pkt_done,
  input  logic [31:0] int_en,
  input  logic        mst_irq_pend,
  output logic [31:0] int_sts,
  output logic        irq
);
  logic [31:0] sts_q, sts_d;
  logic        upd;

  always_comb begin
    sts_d = sts_q;
    if (ack_wr) sts_d[STS_PKT_DONE:0] = '0;
    if (pkt_done) begin
      sts_d[STS_PKT_DONE] = 1'b1;
      sts_d[STS_MATCH]    = 1'b1;
      sts_d[STS_STOP]     = 1'b1;
      sts_d[STS_RX_DONE]  = 1'b1;
    end
    upd = ack_wr | pkt_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else if (upd) sts_q <= sts_d;
  end

  assign int_sts = sts_q;
  assign irq     = mst_irq_pend | (|(sts_q & int_en));

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> (int_sts[STS_PKT_DONE] && int_sts[STS_MATCH] && int_sts[STS_STOP] && int_sts[STS_RX_DONE])); // R5
  AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !pkt_done) |=> (int_sts[STS_PKT_DONE:0] == '0)); // R6
endmodule

// File: rtl/i2c_tgt_rx_dma.sv
module i2c_tgt_rx_dma
  import i2c_trx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  input  logic              addr_stb,
  input  logic [7:0]        addr_byte,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              stop_det,
  input  logic              mst_irq_pend,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  input  logic              mem_ack,
  output logic [31:0]       len_sts,
  output logic [31:0]       int_sts,
  output logic              irq
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              rx_enabled;
  logic [6:0]        tgt_addr;
  logic [LEN_W-1:0]  buf_len;
  logic [ADDR_W-1:0] base_addr;
  logic [31:0]       int_en;
  logic [CNT_W-1:0]  rx_cnt;
  logic              pkt_done;
  logic              ack_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign ack_wr = reg_wr_en & (reg_wr_sel == SEL_ISTS) & reg_wr_data[STS_PKT_DONE];

  i2c_trx_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .rx_enabled(rx_enabled), .tgt_addr(tgt_addr),
    .buf_len(buf_len), .base_addr(base_addr), .int_en(int_en));

  i2c_trx_dma #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dma (
    .clk(clk), .rst_n(rst_core_n), .rx_enabled(rx_enabled), .tgt_addr(tgt_addr),
    .buf_len(buf_len), .base_addr(base_addr), .addr_stb(addr_stb),
    .addr_byte(addr_byte), .byte_vld(byte_vld), .byte_data(byte_data),
    .stop_det(stop_det), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ack(mem_ack), .rx_cnt(rx_cnt), .pkt_done(pkt_done));

  i2c_trx_irq u_irq (
    .clk(clk), .rst_n(rst_core_n), .ack_wr(ack_wr), .pkt_done(pkt_done),
    .int_en(int_en), .mst_irq_pend(mst_irq_pend), .int_sts(int_sts), .irq(irq));

  always_comb begin
    len_sts = '0;
    len_sts[CNT_LSB +: CNT_W] = rx_cnt;
  end

  AST_MST_SHARE: assert property (@(posedge clk) disable iff (!rst_core_n)
    mst_irq_pend |-> irq); // R7
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_core_n)
    (int_sts[STS_PKT_DONE] && int_en[STS_PKT_DONE]) |-> irq); // R7
endmodule

// File: tb/i2c_tgt_rx_dma_tb.sv
module i2c_tgt_rx_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic        addr_stb = 1'b0;
  logic [7:0]  addr_byte = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        stop_det = 1'b0;
  logic        mst_irq_pend = 1'b0;
  logic        mem_ack = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;
  logic [31:0] len_sts, int_sts;
  logic        irq;

  localparam logic [31:0] DONE_SET = 32'h0001_0094;
  localparam logic [6:0]  TADR = 7'h3A;

  int n_chk = 0, n_bad = 0, cyc = 0, wcnt = 0, lat_mode = -1;
  bit finished = 1'b0;
  int exp_n = 0, got_n = 0;
  logic [31:0] exp_a [0:63];
  logic [7:0]  exp_d [0:63];
  int bl_model = 0;
  logic [31:0] base_model = '0;

  always #4 clk = ~clk;

  i2c_tgt_rx_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .addr_stb(addr_stb), .addr_byte(addr_byte),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_det(stop_det),
    .mst_irq_pend(mst_irq_pend), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ack(mem_ack), .len_sts(len_sts),
    .int_sts(int_sts), .irq(irq));

  function automatic int f_stored(int n, int bl);
    return (n < bl) ? n : bl;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: acknowledges with a chosen latency and checks every write
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt == 0) begin
        if (got_n >= exp_n) check("R10 unexpected write", 32'(got_n), 32'(exp_n));
        else begin
          check("R2 write address", mem_addr, exp_a[got_n]);
          check("R2 write data", {24'h0, mem_data}, {24'h0, exp_d[got_n]});
        end
        got_n++;
        mem_ack <= 1'b1;
        wcnt <= (lat_mode < 0) ? int'($urandom_range(3, 0)) : lat_mode;
      end else begin
        wcnt <= wcnt - 1;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(int sel, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = 3'(sel); reg_wr_data = d;
    if (sel == 3 && d[31]) bl_model = int'(d[26:16]);
    if (sel == 4) base_model = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic send_addr(logic [6:0] a, logic rw);
    @(negedge clk);
    addr_stb = 1'b1; addr_byte = {a, rw};
    @(negedge clk);
    addr_stb = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk);
    stop_det = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
  endtask

  // one packet; expected writes are computed when the packet is accepted
  task automatic packet(logic [6:0] a, logic rw, int n, int gap, bit accept);
    exp_n = 0; got_n = 0;
    send_addr(a, rw);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (accept && i < f_stored(n, bl_model)) begin
        exp_a[exp_n] = base_model + 32'(i);
        exp_d[exp_n] = d;
        exp_n++;
      end
      send_byte(d);
      idle(gap);
    end
    send_stop();
    idle(12);
  endtask

  task automatic clear_sts();
    wr_reg(6, 32'h0001_0000);
    idle(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check("R7 reset irq", {31'h0, irq}, 32'h0);
    check("R9 reset mem_req", {31'h0, mem_req}, 32'h0);
    check("R5 reset int_sts", int_sts, 32'h0);
    check("R2 reset len_sts", len_sts, 32'h0);

    wr_reg(0, 32'h2);
    wr_reg(1, 32'h0001_0200);
    wr_reg(2, {25'h0, TADR});
    wr_reg(4, 32'h0000_1000);
    wr_reg(3, 32'h8000_0000 | (32'd16 << 16));
    wr_reg(5, DONE_SET);

    // basic packet
    packet(TADR, 1'b0, 5, 5, 1'b1);
    check("R2 received length", {19'h0, len_sts[28:16]}, 32'd5);
    check("R2 write count", 32'(got_n), 32'd5);
    check("R5 done status", int_sts, DONE_SET);
    check("R7 irq from status", {31'h0, irq}, 32'h1);

    // acknowledge semantics
    wr_reg(6, 32'h0000_0010);
    idle(1);
    check("R6 write without bit16 ignored", int_sts, DONE_SET);
    clear_sts();
    check("R6 bit16 write clears", int_sts, 32'h0);
    check("R7 irq low after clear", {31'h0, irq}, 32'h0);

    // start clears length before data
    exp_n = 0; got_n = 0;
    send_addr(TADR, 1'b0);
    check("R1 length cleared at start", {19'h0, len_sts[28:16]}, 32'd0);
    send_stop();
    idle(6);
    check("R5 empty packet completes", int_sts, DONE_SET);
    clear_sts();

    // length qualifier and buffer exhaustion
    wr_reg(3, 32'h8000_0000 | (32'd2 << 16));
    wr_reg(3, 32'd20 << 16);
    packet(TADR, 1'b0, 4, 5, 1'b1);
    check("R3 length kept without qualifier", 32'(got_n), 32'd2);
    check("R4 extra bytes not counted", {19'h0, len_sts[28:16]}, 32'd2);
    check("R4 packet still completes", int_sts, DONE_SET);
    clear_sts();

    // foreign address and read direction
    wr_reg(3, 32'h8000_0000 | (32'd16 << 16));
    packet(7'h11, 1'b0, 3, 5, 1'b0);
    check("R10 foreign address no write", 32'(got_n), 32'd0);
    check("R10 foreign address length", {19'h0, len_sts[28:16]}, 32'd2);
    check("R10 foreign address status", int_sts, 32'h0);
    packet(TADR, 1'b1, 3, 5, 1'b0);
    check("R10 read direction no write", 32'(got_n), 32'd0);
    check("R10 read direction status", int_sts, 32'h0);

    // enable gating
    wr_reg(1, 32'h0001_0000);
    packet(TADR, 1'b0, 3, 5, 1'b0);
    check("R8 dma disabled no write", 32'(got_n), 32'd0);
    check("R8 dma disabled status", int_sts, 32'h0);
    wr_reg(1, 32'h0001_0200);
    wr_reg(0, 32'h0);
    packet(TADR, 1'b0, 3, 5, 1'b0);
    check("R8 target disabled no write", 32'(got_n), 32'd0);
    wr_reg(0, 32'h2);

    // skid: two back-to-back bytes against a slow memory
    lat_mode = 3;
    packet(TADR, 1'b0, 2, 0, 1'b1);
    check("R9 skid keeps both bytes", 32'(got_n), 32'd2);
    check("R9 skid length", {19'h0, len_sts[28:16]}, 32'd2);
    lat_mode = -1;
    clear_sts();

    // shared line
    mst_irq_pend = 1'b1;
    idle(1);
    check("R7 master pending drives line", {31'h0, irq}, 32'h1);
    packet(TADR, 1'b0, 1, 5, 1'b1);
    mst_irq_pend = 1'b0;
    idle(1);
    check("R7 line stays while target pending", {31'h0, irq}, 32'h1);
    clear_sts();
    check("R7 line drops when both clear", {31'h0, irq}, 32'h0);
    wr_reg(5, 32'h0);
    packet(TADR, 1'b0, 1, 5, 1'b1);
    check("R7 masked status sets", int_sts, DONE_SET);
    check("R7 masked status no irq", {31'h0, irq}, 32'h0);
    wr_reg(5, 32'h0000_0004);
    idle(1);
    check("R7 enable of one bit raises line", {31'h0, irq}, 32'h1);
    clear_sts();
    wr_reg(5, DONE_SET);

    // random packets
    for (int k = 0; k < 8; k++) begin
      int n, bl;
      n  = int'($urandom_range(14, 1));
      bl = int'($urandom_range(12, 0));
      wr_reg(3, 32'h8000_0000 | (32'(bl) << 16));
      wr_reg(4, 32'h0000_2000 + 32'($urandom_range(255, 0)));
      packet(TADR, 1'b0, n, int'($urandom_range(8, 5)), 1'b1);
      check("R2 random length", {19'h0, len_sts[28:16]}, 32'(f_stored(n, bl)));
      check("R4 random write count", 32'(got_n), 32'(f_stored(n, bl)));
      check("R5 random status", int_sts, DONE_SET);
      clear_sts();
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule